// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address that missed in a translation cache. It walks two levels of in-memory tables. First it fetches a directory entry, indexed by the top ten address bits, from a table at a given base. If that entry is valid, it fetches a page entry, indexed by the next ten bits, from the table the directory entry points to. If the page entry is valid and grants the requested access, it returns the physical address together with the page's permission and cache-attribute flags.

Any walk can end in one of three ways: success, a page fault, or a bus fault. A page fault comes from an invalid entry or a missing permission. A bus fault comes from a read error on the memory port. Every outcome reports the virtual address and the direction of the access that caused it.

The walker talks to memory through a simple read port with one read outstanding at a time. A read is a single-cycle request pulse. The response comes some cycles later as a data word with a valid strobe and an error flag. The walker takes a new request only when it is idle. It ends each walk with a one-cycle done pulse, and the result outputs then hold until the next walk completes.

Top module: `twalk_top`

## Requirements
- R1: After reset the walker is idle: `reqReady` is 1, and `done` and `memRdReq` are 0.
- R2: The first read of a walk is issued as a one-cycle `memRdReq` pulse with address `dirBase + 4*vaddr[31:22]`. No further read is issued until the response (`memRdValid`) has been seen.
- R3: When the directory entry has bit 0 set, the second read goes to `{dirEntry[31:12], 12'h000} + 4*vaddr[21:12]`.
- R4: A directory entry with bit 0 clear ends the walk with a page fault, and no second read is issued.
- R5: A page entry with bit 0 clear ends the walk with a page fault.
- R6: In a page entry, bit 1 grants read and bit 2 grants write. A write without bit 2, or a read without bit 1, ends the walk with a page fault.
- R7: A successful walk returns `resPaddr = {pageEntry[31:12], vaddr[11:0]}`, with `resReadable` and `resWritable` equal to page entry bits 1 and 2.
- R8: On success, `resAttrOvr` equals page entry bit 3. `resAttr` equals page entry bits 8:4 when bit 3 is set, and 0 otherwise.
- R9: A response with `memRdErr` set, in either phase, ends the walk with a bus fault and no page fault, whatever the data word holds.
- R10: For every outcome, `resVaddr` and `resWrite` report the virtual address and the write flag of the completed walk.
- R11: `done` is high for exactly one cycle per walk. In that cycle exactly one of `walkOk`, `faultPage` and `faultBus` is set. Result outputs hold until the next walk ends. On a fault, `resPaddr` and all flags are 0.
- R12: Requests presented while a walk is in progress are ignored. The walker is idle again in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | New walk request, accepted only while idle |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 for a write access, 0 for a read |
| dirBase | input | 32 | Byte address of the directory table, held stable during a walk |
| reqReady | output | 1 | Walker idle, a request is taken this cycle |
| memRdReq | output | 1 | One-cycle read request |
| memRdAddr | output | 32 | Read address, valid with memRdReq |
| memRdValid | input | 1 | Read response strobe |
| memRdData | input | 32 | Read response word |
| memRdErr | input | 1 | Read response carries a bus error |
| done | output | 1 | One-cycle end-of-walk pulse |
| walkOk | output | 1 | Last walk translated successfully |
| faultPage | output | 1 | Last walk ended with a page fault |
| faultBus | output | 1 | Last walk ended with a bus fault |
| resPaddr | output | 32 | Translated physical address |
| resReadable | output | 1 | Page grants read |
| resWritable | output | 1 | Page grants write |
| resAttrOvr | output | 1 | Page cache-attribute override enabled |
| resAttr | output | 5 | Page cache attributes when override is enabled |
| resVaddr | output | 32 | Virtual address of the last walk |
| resWrite | output | 1 | Direction of the last walk |

## Verification
The hardest case is a response word that carries a bus error and, in the same cycle, decodes as an invalid or permission-failing entry. Both the error path and the entry-decode path then want to decide the outcome. The bench provokes this directly: it returns erroring responses whose data has bit 0 clear, or lacks the permission bit the access needs, in both the directory phase and the page phase. It judges the result by requiring `faultBus` alone, with `faultPage` low. The same collision is also reached by random stimulus that draws error flags and entry bits independently.

// File: rtl/twalk_pkg.sv
package twalk_pkg;

  // Entry bit positions shared by directory and page entries
  localparam int ENT_VALID   = 0;
  localparam int ENT_RD      = 1;
  localparam int ENT_WR      = 2;
  localparam int ENT_OVR     = 3;
  localparam int ENT_ATTR_LO = 4;
  localparam int ENT_ATTR_HI = 8;
  localparam int ATTR_W      = ENT_ATTR_HI - ENT_ATTR_LO + 1;
  localparam int ENTRY_SHIFT = 2;  // entries are 4 bytes

  typedef enum logic [1:0] {
    RES_OK   = 2'd0,
    RES_PAGE = 2'd1,
    RES_BUS  = 2'd2
  } walkRes_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     capReq;      // latch request address and direction
    logic     capTable;    // latch table address from directory entry
    logic     capResult;   // latch outcome and result fields
    logic     usePteAddr;  // address mux selects second-level address
    walkRes_e resKind;     // outcome to record with capResult
  } walkStrobe_t;

endpackage

// File: rtl/twalk_ctrl.sv
module twalk_ctrl
  import twalk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        memRdReq,
  input  logic        memRdValid,
  input  logic        memRdErr,
  input  logic        entryValid,
  input  logic        permOk,
  output walkStrobe_t strobe,
  output logic        done
);

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DIR_REQ  = 3'd1,
    ST_DIR_WAIT = 3'd2,
    ST_PTE_REQ  = 3'd3,
    ST_PTE_WAIT = 3'd4,
    ST_DONE     = 3'd5
  } walkState_e;

  walkState_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt          = state;
    reqReady          = 1'b0;
    memRdReq          = 1'b0;
    done              = 1'b0;
    strobe.capReq     = 1'b0;
    strobe.capTable   = 1'b0;
    strobe.capResult  = 1'b0;
    strobe.usePteAddr = 1'b0;
    strobe.resKind    = RES_OK;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capReq = 1'b1;
          stateNxt      = ST_DIR_REQ;
        end
      end
      ST_DIR_REQ: begin
        memRdReq = 1'b1;
        stateNxt = ST_DIR_WAIT;
      end
      ST_DIR_WAIT: begin
        if (memRdValid) begin
          if (memRdErr) begin
            strobe.capResult = 1'b1;
            strobe.resKind   = RES_BUS;
            stateNxt         = ST_DONE;
          end else if (!entryValid) begin
            strobe.capResult = 1'b1;
            strobe.resKind   = RES_PAGE;
            stateNxt         = ST_DONE;
          end else begin
            strobe.capTable = 1'b1;
            stateNxt        = ST_PTE_REQ;
          end
        end
      end
      ST_PTE_REQ: begin
        memRdReq          = 1'b1;
        strobe.usePteAddr = 1'b1;
        stateNxt          = ST_PTE_WAIT;
      end
      ST_PTE_WAIT: begin
        strobe.usePteAddr = 1'b1;
        if (memRdValid) begin
          strobe.capResult = 1'b1;
          stateNxt         = ST_DONE;
          if (memRdErr)                   strobe.resKind = RES_BUS;
          else if (!entryValid || !permOk) strobe.resKind = RES_PAGE;
          else                            strobe.resKind = RES_OK;
        end
      end
      ST_DONE: begin
        done     = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  // R2
  rd_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |=> !memRdReq);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> reqReady);

endmodule

// File: rtl/twalk_dpath.sv
module twalk_dpath
  import twalk_pkg::*;
#(
  parameter int DIR_IDX_W = 10,
  parameter int PT_IDX_W  = 10,
  parameter int OFF_W     = 12,
  localparam int ADDR_W   = DIR_IDX_W + PT_IDX_W + OFF_W,
  localparam int FRAME_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic [ADDR_W-1:0] memRdData,
  input  walkStrobe_t       strobe,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              entryValid,
  output logic              permOk,
  output logic              walkOk,
  output logic              faultPage,
  output logic              faultBus,
  output logic [ADDR_W-1:0] resPaddr,
  output logic              resReadable,
  output logic              resWritable,
  output logic              resAttrOvr,
  output logic [ATTR_W-1:0] resAttr,
  output logic [ADDR_W-1:0] resVaddr,
  output logic              resWrite
);

  logic [ADDR_W-1:0]    vaddrQ;
  logic                 writeQ;
  logic [FRAME_W-1:0]   tableQ;
  logic [DIR_IDX_W-1:0] dirIdx;
  logic [PT_IDX_W-1:0]  ptIdx;
  logic [OFF_W-1:0]     pageOff;
  logic [ADDR_W-1:0]    dirEntAddr;
  logic [ADDR_W-1:0]    pteEntAddr;

  assign dirIdx  = vaddrQ[ADDR_W-1 -: DIR_IDX_W];
  assign ptIdx   = vaddrQ[OFF_W +: PT_IDX_W];
  assign pageOff = vaddrQ[OFF_W-1:0];

  assign dirEntAddr = dirBase + ADDR_W'({dirIdx, {ENTRY_SHIFT{1'b0}}});
  assign pteEntAddr = {tableQ, {OFF_W{1'b0}}} + ADDR_W'({ptIdx, {ENTRY_SHIFT{1'b0}}});
  assign memRdAddr  = strobe.usePteAddr ? pteEntAddr : dirEntAddr;

  assign entryValid = memRdData[ENT_VALID];
  assign permOk     = writeQ ? memRdData[ENT_WR] : memRdData[ENT_RD];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ <= '0;
      writeQ <= 1'b0;
      tableQ <= '0;
    end else begin
      if (strobe.capReq) begin
        vaddrQ <= reqVaddr;
        writeQ <= reqWrite;
      end
      if (strobe.capTable) tableQ <= memRdData[ADDR_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      walkOk      <= 1'b0;
      faultPage   <= 1'b0;
      faultBus    <= 1'b0;
      resPaddr    <= '0;
      resReadable <= 1'b0;
      resWritable <= 1'b0;
      resAttrOvr  <= 1'b0;
      resAttr     <= '0;
      resVaddr    <= '0;
      resWrite    <= 1'b0;
    end else if (strobe.capResult) begin
      walkOk    <= (strobe.resKind == RES_OK);
      faultPage <= (strobe.resKind == RES_PAGE);
      faultBus  <= (strobe.resKind == RES_BUS);
      resVaddr  <= vaddrQ;
      resWrite  <= writeQ;
      if (strobe.resKind == RES_OK) begin
        resPaddr    <= {memRdData[ADDR_W-1:OFF_W], pageOff};
        resReadable <= memRdData[ENT_RD];
        resWritable <= memRdData[ENT_WR];
        resAttrOvr  <= memRdData[ENT_OVR];
        resAttr     <= memRdData[ENT_OVR] ? memRdData[ENT_ATTR_HI:ENT_ATTR_LO] : '0;
      end else begin
        resPaddr    <= '0;
        resReadable <= 1'b0;
        resWritable <= 1'b0;
        resAttrOvr  <= 1'b0;
        resAttr     <= '0;
      end
    end
  end

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capResult |=> $stable(resVaddr) && $stable(resPaddr));

endmodule

// File: rtl/twalk_top.sv
module twalk_top
  import twalk_pkg::*;
#(
  parameter int DIR_IDX_W = 10,
  parameter int PT_IDX_W  = 10,
  parameter int OFF_W     = 12,
  localparam int ADDR_W   = DIR_IDX_W + PT_IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] dirBase,
  output logic              reqReady,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdValid,
  input  logic [ADDR_W-1:0] memRdData,
  input  logic              memRdErr,
  output logic              done,
  output logic              walkOk,
  output logic              faultPage,
  output logic              faultBus,
  output logic [ADDR_W-1:0] resPaddr,
  output logic              resReadable,
  output logic              resWritable,
  output logic              resAttrOvr,
  output logic [ATTR_W-1:0] resAttr,
  output logic [ADDR_W-1:0] resVaddr,
  output logic              resWrite
);

  walkStrobe_t strobe;
  logic        entryValid;
  logic        permOk;

  twalk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .memRdReq   (memRdReq),
    .memRdValid (memRdValid),
    .memRdErr   (memRdErr),
    .entryValid (entryValid),
    .permOk     (permOk),
    .strobe     (strobe),
    .done       (done)
  );

  twalk_dpath #(
    .DIR_IDX_W (DIR_IDX_W),
    .PT_IDX_W  (PT_IDX_W),
    .OFF_W     (OFF_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .reqVaddr    (reqVaddr),
    .reqWrite    (reqWrite),
    .dirBase     (dirBase),
    .memRdData   (memRdData),
    .strobe      (strobe),
    .memRdAddr   (memRdAddr),
    .entryValid  (entryValid),
    .permOk      (permOk),
    .walkOk      (walkOk),
    .faultPage   (faultPage),
    .faultBus    (faultBus),
    .resPaddr    (resPaddr),
    .resReadable (resReadable),
    .resWritable (resWritable),
    .resAttrOvr  (resAttrOvr),
    .resAttr     (resAttr),
    .resVaddr    (resVaddr),
    .resWrite    (resWrite)
  );

  // R11
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $countones({walkOk, faultPage, faultBus}) == 1);

  // R7
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && walkOk) |-> resPaddr[OFF_W-1:0] == resVaddr[OFF_W-1:0]);

  // R6
  write_perm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && walkOk) |-> (resWrite ? resWritable : resReadable));

  // R8
  attr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !resAttrOvr) |-> resAttr == '0);

endmodule

// File: tb/twalk_top_bench.sv
module twalk_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] dirBase = '0;
  logic        reqReady;
  logic        memRdReq;
  logic [31:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        memRdErr = 1'b0;
  logic        done, walkOk, faultPage, faultBus;
  logic [31:0] resPaddr, resVaddr;
  logic        resReadable, resWritable, resAttrOvr, resWrite;
  logic [4:0]  resAttr;

  int nChecks = 0;
  int nErrors = 0;

  always #5 clk = ~clk;

  twalk_top u_twalk_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .dirBase(dirBase), .reqReady(reqReady),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .memRdErr(memRdErr), .done(done), .walkOk(walkOk),
    .faultPage(faultPage), .faultBus(faultBus), .resPaddr(resPaddr),
    .resReadable(resReadable), .resWritable(resWritable),
    .resAttrOvr(resAttrOvr), .resAttr(resAttr), .resVaddr(resVaddr),
    .resWrite(resWrite)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expDirAddr(input logic [31:0] base, input logic [31:0] va);
    return base + {20'h0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] expPteAddr(input logic [31:0] dte, input logic [31:0] va);
    return {dte[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
  endfunction

  function automatic string causeTag(input bit isBus, input logic [31:0] dte,
                                     input logic [31:0] pte, input bit isPage);
    if (isBus)       return "R9";
    if (!dte[0])     return "R4";
    if (!pte[0])     return "R5";
    if (isPage)      return "R6";
    return "R7";
  endfunction

  // One full walk; called at a falling edge while the walker is idle
  task automatic doWalk(input logic [31:0] va, input bit wr, input logic [31:0] base,
                        input logic [31:0] dte, input logic [31:0] pte,
                        input bit e0, input bit e1, input bit noise);
    bit expBus, expPage, expOk, gotDone;
    int nReads, waitc;
    logic [31:0] expA;
    string tag;
    expBus  = e0 || (dte[0] && e1);
    expPage = !expBus && (!dte[0] || !pte[0] || (wr ? !pte[2] : !pte[1]));
    expOk   = !expBus && !expPage;
    nReads  = (e0 || !dte[0]) ? 1 : 2;
    tag     = causeTag(expBus, dte, pte, expPage);

    chk(reqReady == 1'b1, "R12", {31'h0, reqReady}, 32'h1);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr; dirBase = base;
    @(negedge clk);
    if (noise) begin
      reqVaddr = ~va; reqWrite = !wr;  // ignored while busy (R12)
    end else begin
      reqValid = 1'b0;
    end
    gotDone = 1'b0;
    for (int ph = 0; ph < 2; ph++) begin
      waitc = 0;
      while (!memRdReq && !done && waitc < 20) begin
        @(negedge clk); waitc++;
      end
      if (done) begin
        gotDone = 1'b1;
        break;
      end
      if (!memRdReq) begin
        chk(1'b0, "R2", 32'h0, 32'h1);
        break;
      end
      chk(ph < nReads, e0 ? "R9" : "R4", ph, nReads - 1);
      expA = (ph == 0) ? expDirAddr(base, va) : expPteAddr(dte, va);
      chk(memRdAddr == expA, (ph == 0) ? "R2" : "R3", memRdAddr, expA);
      @(negedge clk);
      chk(!memRdReq, "R2", {31'h0, memRdReq}, 32'h0);
      repeat ($urandom_range(0, 3)) begin
        @(negedge clk);
        chk(!memRdReq && !done, "R2", {30'h0, memRdReq, done}, 32'h0);
      end
      memRdValid = 1'b1;
      memRdData  = (ph == 0) ? dte : pte;
      memRdErr   = (ph == 0) ? e0 : e1;
      @(negedge clk);
      memRdValid = 1'b0; memRdErr = 1'b0; memRdData = $urandom;
    end
    if (!gotDone) begin
      waitc = 0;
      while (!done && waitc < 20) begin
        @(negedge clk); waitc++;
      end
    end
    chk(done == 1'b1, "R11", {31'h0, done}, 32'h1);
    chk(walkOk == expOk && faultPage == expPage && faultBus == expBus, tag,
        {29'h0, walkOk, faultPage, faultBus}, {29'h0, expOk, expPage, expBus});
    chk($countones({walkOk, faultPage, faultBus}) == 1, "R11",
        {29'h0, walkOk, faultPage, faultBus}, 32'h1);
    chk(resVaddr == va, "R10", resVaddr, va);
    chk(resWrite == wr, "R10", {31'h0, resWrite}, {31'h0, wr});
    if (expOk) begin
      chk(resPaddr == {pte[31:12], va[11:0]}, "R7", resPaddr, {pte[31:12], va[11:0]});
      chk(resReadable == pte[1] && resWritable == pte[2], "R7",
          {30'h0, resReadable, resWritable}, {30'h0, pte[1], pte[2]});
      chk(resAttrOvr == pte[3], "R8", {31'h0, resAttrOvr}, {31'h0, pte[3]});
      chk(resAttr == (pte[3] ? pte[8:4] : 5'h0), "R8", {27'h0, resAttr},
          {27'h0, (pte[3] ? pte[8:4] : 5'h0)});
    end else begin
      chk(resPaddr == 32'h0 && !resReadable && !resWritable && !resAttrOvr && resAttr == 5'h0,
          "R11", resPaddr, 32'h0);
    end
    reqValid = 1'b0;
    @(negedge clk);
    chk(!done, "R11", {31'h0, done}, 32'h0);
    chk(reqReady, "R12", {31'h0, reqReady}, 32'h1);
    chk(resVaddr == va, "R11", resVaddr, va);
  endtask

  initial begin
    #(200000 * 10);
    nErrors++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [31:0] va, base, dte, pte;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1", {31'h0, reqReady}, 32'h1);
    chk(done == 1'b0 && memRdReq == 1'b0, "R1", {30'h0, done, memRdReq}, 32'h0);

    // Directed corners
    doWalk(32'h0040_1abc, 0, 32'h1000_0000, 32'h2000_0001, 32'h3000_0003, 0, 0, 0); // R7 read ok
    doWalk(32'h0040_1abc, 0, 32'h1000_0000, 32'h2000_0000, 32'h3000_0003, 0, 0, 0); // R4
    doWalk(32'h0080_2000, 1, 32'h1000_0000, 32'h2000_0001, 32'h3000_0006, 0, 0, 0); // R5
    doWalk(32'h0080_2000, 0, 32'h1000_0000, 32'h2000_0001, 32'h3000_0005, 0, 0, 0); // R6 no read perm
    doWalk(32'h0080_2000, 1, 32'h1000_0000, 32'h2000_0001, 32'h3000_0003, 0, 0, 0); // R6 no write perm
    doWalk(32'h0080_2fff, 1, 32'h1000_0000, 32'h2000_0001, 32'h3000_0005, 0, 0, 0); // R6 write ok
    doWalk(32'hffff_ffff, 0, 32'h1000_0000, 32'hffff_f001, 32'habcd_e1fb, 0, 0, 0); // R8 ovr on
    doWalk(32'h1234_5678, 0, 32'h0000_0ffc, 32'h2000_0001, 32'habcd_e1f3, 0, 0, 0); // R8 ovr off
    doWalk(32'h1234_5678, 0, 32'h1000_0000, 32'h2000_0000, 32'h3000_0003, 1, 0, 0); // R9 err + invalid
    doWalk(32'h1234_5678, 1, 32'h1000_0000, 32'h2000_0001, 32'h3000_0002, 0, 1, 0); // R9 err + no perm
    doWalk(32'h1234_5678, 0, 32'h1000_0000, 32'h2000_0001, 32'h3000_0003, 0, 1, 0); // R9 err on ok data
    doWalk(32'h0c0f_f123, 1, 32'h1000_0000, 32'h2000_0001, 32'h3000_0007, 0, 0, 1); // R12 busy requests

    // Random walks
    for (int i = 0; i < 200; i++) begin
      va   = $urandom;
      base = $urandom & 32'hffff_fffc;
      dte  = ($urandom & 32'hffff_f000) | (($urandom_range(0, 9) != 0) ? 32'h1 : 32'h0);
      pte  = ($urandom & 32'hffff_f1fe) | (($urandom_range(0, 9) != 0) ? 32'h1 : 32'h0);
      doWalk(va, 1'($urandom), base, dte, pte, $urandom_range(0, 11) == 0,
             $urandom_range(0, 11) == 0, $urandom_range(0, 5) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule